// File: doc/BRIEF.md
# Card Command Issue and Status Unit

This unit sits between a register-mapped host interface and the card-side command engine of a memory-card host controller. Software loads a 32-bit argument as two 16-bit halves, then writes a 16-bit command word. When the unit is enabled and no reply is outstanding, it pulses a request carrying the command index and the assembled argument. For data-bearing commands it also arms the data-transfer path. It then waits for the card engine to return a reply, given as a 16-byte vector plus a byte count.

When the reply arrives, the unit checks its length against the response class selected in the command word. It inspects the 32-bit card status for errors or a power-up flag, stores the reply bytes into eight 16-bit response registers, and raises completion bits in a 16-bit status register. Software clears status bits by writing ones to them. A 15-bit enable mask selects which status bits drive the interrupt line.

Register addresses (4-bit): 0 command, 1 argument low half, 2 argument high half, 3 control (bit 11 = enable), 4 status, 5 interrupt mask, 8..15 response registers 0..7. Reads return data one cycle after the read address is presented.

Top module: `cmd_status_unit`

## Requirements
- R1: A command write (address 0) is ignored while control bit 11 is clear, or while an earlier command still awaits its reply. Read-back of the command register is then unchanged, and no card request is issued.
- R2: Writing the control register with bit 11 clear zeroes the status register, drops any outstanding reply wait, and pulses `fifo_flush` for one cycle.
- R3: An accepted command (index in bits 5:0) produces a one-cycle `card_req` pulse in the cycle after the write. The pulse carries that index and the argument formed from the high half (address 2) and the low half (address 1).
- R4: An accepted command with init flag (bit 7) set and index 0 sets only status bit 0, at once. It issues no card request and waits for no reply.
- R5: Response class is taken from bits 10:8: value 1 (with or without busy bit 11), 3 and 6 need a reply of at least 4 bytes, and value 2 needs 16 bytes. A shorter reply sets timeout status bit 7 instead of bit 0, and the response registers stay zero.
- R6: For class 1, the card status is the big-endian word {byte0,byte1,byte2,byte3}. If it has any bit of error mask 0xFDF90000 set, status bit 14 is also set. Other set bits have no effect.
- R7: For class 3, a card status with bit 31 clear also sets status bit 12. With bit 31 set, bit 12 is not set.
- R8: A reply that is not short sets status bit 0. For command index 12 it sets bits 0 and 2.
- R9: On an accepted reply of sufficient length, response register 7−k receives byte 2k as its high byte and byte 2k+1 as its low byte. All eight registers are cleared on every accepted command write.
- R10: An accepted command of type 3 (bits 13:12) pulses `fifo_flush` and sets `xfer_active`, with `xfer_dir` taken from bit 15. Any other type clears `xfer_active`.
- R11: Writing the status register clears the bits written as 1. A status bit set by the unit in the same cycle stays set.
- R12: `irq` is high exactly when any status bit is set whose bit is also set in the 15-bit mask (bits 14:0 of address 5). Mask bit 15 is not stored.
- R13: Response classes 0, 4, 5 and 7 store nothing and only set the completion bits of R8. A reply arriving while no command is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_rd_addr | input | 4 | Read address |
| reg_rdata | output | 16 | Registered read data, one cycle after address |
| card_req | output | 1 | One-cycle request to the card engine |
| card_req_index | output | 6 | Command index of the request |
| card_req_arg | output | 32 | Argument of the request |
| card_rsp_valid | input | 1 | Card reply present this cycle |
| card_rsp_len | input | 5 | Reply byte count |
| card_rsp_data | input | 128 | Reply bytes, byte 0 in bits 7:0 |
| xfer_active | output | 1 | Data transfer armed |
| xfer_dir | output | 1 | Direction latched from the command |
| fifo_flush | output | 1 | One-cycle data buffer flush |
| irq | output | 1 | Interrupt request |

## Verification
Two events can reach the status register in the same clock: a software write-one-to-clear, and the completion bits raised by an arriving card reply. The bench puts status bit 0 in the set state, issues a second command, and then drives the status write clearing bit 0 in the same cycle as the reply. Bit 0 must read back set. A lone clear afterwards must read zero, which shows that the clear path works and that set priority alone kept the bit.

// File: rtl/cmdst_pkg.sv
package cmdst_pkg;

  localparam int REG_W = 16;

  localparam logic [3:0] A_CMD  = 4'd0;
  localparam logic [3:0] A_ARGL = 4'd1;
  localparam logic [3:0] A_ARGH = 4'd2;
  localparam logic [3:0] A_CTRL = 4'd3;
  localparam logic [3:0] A_STAT = 4'd4;
  localparam logic [3:0] A_IE   = 4'd5;

  localparam int EN_BIT  = 11;
  localparam int ST_DONE = 0;
  localparam int ST_STOP = 2;
  localparam int ST_TMO  = 7;
  localparam int ST_OCR  = 12;
  localparam int ST_CERR = 14;

  localparam logic [1:0] CT_DATA  = 2'd3;
  localparam logic [5:0] IDX_STOP = 6'd12;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_R1,
    RK_R1B,
    RK_R2,
    RK_R3,
    RK_R6
  } rsp_kind_e;

  typedef struct packed {
    logic       dir;
    logic [1:0] ctype;
    rsp_kind_e  kind;
    logic       init;
    logic [5:0] index;
  } cmd_fields_t;

endpackage

// File: rtl/cmdst_decode.sv
module cmdst_decode
  import cmdst_pkg::*;
(
  input  logic [REG_W-1:0] word,
  output cmd_fields_t      fields
);

  always_comb begin
    fields.index = word[5:0];
    fields.init  = word[7];
    fields.ctype = word[13:12];
    fields.dir   = word[15];
    unique case (word[10:8])
      3'd1:    fields.kind = word[11] ? RK_R1B : RK_R1;
      3'd2:    fields.kind = RK_R2;
      3'd3:    fields.kind = RK_R3;
      3'd6:    fields.kind = RK_R6;
      default: fields.kind = RK_NONE;
    endcase
  end

endmodule

// File: rtl/cmdst_resp_eval.sv
module cmdst_resp_eval
  import cmdst_pkg::*;
#(
  parameter int          RSP_BYTES = 16,
  parameter int          LEN_W     = $clog2(RSP_BYTES + 1),
  parameter logic [31:0] ERR_MASK  = 32'hFDF9_0000
) (
  input  rsp_kind_e                kind,
  input  logic [5:0]               index,
  input  logic [LEN_W-1:0]         len,
  input  logic [RSP_BYTES*8-1:0]   data,
  output logic                     store,
  output logic [REG_W-1:0]         set_bits
);

  localparam logic [LEN_W-1:0] SHORT_NEED = LEN_W'(4);
  localparam logic [LEN_W-1:0] LONG_NEED  = LEN_W'(RSP_BYTES);

  logic [LEN_W-1:0] need;
  logic             expects;
  logic             short_rsp;
  logic [31:0]      card_word;

  always_comb begin
    unique case (kind)
      RK_R1, RK_R1B, RK_R3, RK_R6: need = SHORT_NEED;
      RK_R2:                       need = LONG_NEED;
      default:                     need = '0;
    endcase
    expects   = (kind != RK_NONE);
    short_rsp = expects && (len < need);
    store     = expects && !short_rsp;
    card_word = {data[7:0], data[15:8], data[23:16], data[31:24]};

    set_bits = '0;
    if (short_rsp) begin
      set_bits[ST_TMO] = 1'b1;
    end else begin
      set_bits[ST_DONE] = 1'b1;
      if (index == IDX_STOP) set_bits[ST_STOP] = 1'b1;
      if ((kind == RK_R1 || kind == RK_R1B) && |(card_word & ERR_MASK))
        set_bits[ST_CERR] = 1'b1;
      if (kind == RK_R3 && !card_word[31])
        set_bits[ST_OCR] = 1'b1;
    end
  end

endmodule

// File: rtl/cmdst_status.sv
module cmdst_status
  import cmdst_pkg::*;
#(
  parameter int IE_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic [REG_W-1:0] clr_bits,
  input  logic [REG_W-1:0] set_bits,
  input  logic             ie_wr,
  input  logic [IE_W-1:0]  ie_wdata,
  output logic [REG_W-1:0] status_q,
  output logic [IE_W-1:0]  ie_q,
  output logic             irq_q
);

  logic [REG_W-1:0] status_d;
  logic [IE_W-1:0]  ie_d;

  always_comb begin
    if (clr_all) status_d = '0;
    else         status_d = (status_q & ~clr_bits) | set_bits;
    ie_d = ie_wr ? ie_wdata : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ie_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      ie_q     <= ie_d;
      irq_q    <= |(status_d[IE_W-1:0] & ie_d);
    end
  end

endmodule

// File: rtl/cmdst_rsp_bank.sv
module cmdst_rsp_bank
  import cmdst_pkg::*;
#(
  parameter int RSP_REGS = 8,
  parameter int IDX_W    = $clog2(RSP_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      load,
  input  logic [RSP_REGS*16-1:0]    bytes_in,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [REG_W-1:0]          rd_data
);

  logic [REG_W-1:0] bank_q [RSP_REGS];

  for (genvar j = 0; j < RSP_REGS; j++) begin : g_slot
    localparam int K = RSP_REGS - 1 - j;
    always_ff @(posedge clk) begin
      if (rst || clear)
        bank_q[j] <= '0;
      else if (load)
        bank_q[j] <= {bytes_in[16*K +: 8], bytes_in[16*K + 8 +: 8]};
    end
  end

  assign rd_data = bank_q[rd_idx];

endmodule

// File: rtl/cmd_status_unit.sv
module cmd_status_unit
  import cmdst_pkg::*;
#(
  parameter int          RSP_REGS  = 8,
  parameter int          IE_W      = 15,
  parameter logic [31:0] ERR_MASK  = 32'hFDF9_0000,
  parameter int          RSP_BYTES = 2 * RSP_REGS,
  parameter int          LEN_W     = $clog2(RSP_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic [3:0]             reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  input  logic [3:0]             reg_rd_addr,
  output logic [REG_W-1:0]       reg_rdata,
  output logic                   card_req,
  output logic [5:0]             card_req_index,
  output logic [31:0]            card_req_arg,
  input  logic                   card_rsp_valid,
  input  logic [LEN_W-1:0]       card_rsp_len,
  input  logic [RSP_BYTES*8-1:0] card_rsp_data,
  output logic                   xfer_active,
  output logic                   xfer_dir,
  output logic                   fifo_flush,
  output logic                   irq
);

  localparam int IDX_W = $clog2(RSP_REGS);

  logic [REG_W-1:0] cmd_q, ctrl_q, argl_q, argh_q;
  logic             pending_q;
  logic             enable_q;
  logic [REG_W-1:0] status_q;
  logic [IE_W-1:0]  ie_q;

  cmd_fields_t new_f, held_f;

  cmdst_decode u_dec_new  (.word(reg_wdata), .fields(new_f));
  cmdst_decode u_dec_held (.word(cmd_q),     .fields(held_f));

  assign enable_q = ctrl_q[EN_BIT];

  logic wr_cmd, wr_ctrl, wr_stat, wr_ie;
  logic cmd_accept, init_zero, disable_wr, rsp_take;

  assign wr_cmd     = reg_wr && (reg_addr == A_CMD);
  assign wr_ctrl    = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat    = reg_wr && (reg_addr == A_STAT);
  assign wr_ie      = reg_wr && (reg_addr == A_IE);
  assign cmd_accept = wr_cmd && enable_q && !pending_q;
  assign init_zero  = new_f.init && (new_f.index == 6'd0);
  assign disable_wr = wr_ctrl && !reg_wdata[EN_BIT];
  assign rsp_take   = pending_q && card_rsp_valid && !disable_wr;

  logic             rsp_store;
  logic [REG_W-1:0] rsp_set;

  cmdst_resp_eval #(
    .RSP_BYTES(RSP_BYTES),
    .LEN_W    (LEN_W),
    .ERR_MASK (ERR_MASK)
  ) u_eval (
    .kind    (held_f.kind),
    .index   (held_f.index),
    .len     (card_rsp_len),
    .data    (card_rsp_data),
    .store   (rsp_store),
    .set_bits(rsp_set)
  );

  logic [REG_W-1:0] set_bits, clr_bits;

  always_comb begin
    set_bits = '0;
    if (cmd_accept && init_zero) set_bits[ST_DONE] = 1'b1;
    if (rsp_take)                set_bits = set_bits | rsp_set;
    clr_bits = wr_stat ? reg_wdata : '0;
  end

  cmdst_status #(.IE_W(IE_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .clr_all (disable_wr),
    .clr_bits(clr_bits),
    .set_bits(set_bits),
    .ie_wr   (wr_ie),
    .ie_wdata(reg_wdata[IE_W-1:0]),
    .status_q(status_q),
    .ie_q    (ie_q),
    .irq_q   (irq)
  );

  logic [REG_W-1:0] rsp_rd;

  cmdst_rsp_bank #(.RSP_REGS(RSP_REGS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .clear   (cmd_accept),
    .load    (rsp_take && rsp_store),
    .bytes_in(card_rsp_data),
    .rd_idx  (reg_rd_addr[IDX_W-1:0]),
    .rd_data (rsp_rd)
  );

  // Register file and command sequencing.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q          <= '0;
      ctrl_q         <= '0;
      argl_q         <= '0;
      argh_q         <= '0;
      pending_q      <= 1'b0;
      card_req       <= 1'b0;
      card_req_index <= '0;
      card_req_arg   <= '0;
      xfer_active    <= 1'b0;
      xfer_dir       <= 1'b0;
      fifo_flush     <= 1'b0;
    end else begin
      card_req   <= 1'b0;
      fifo_flush <= 1'b0;
      if (reg_wr && reg_addr == A_ARGL) argl_q <= reg_wdata;
      if (reg_wr && reg_addr == A_ARGH) argh_q <= reg_wdata;
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (rsp_take) pending_q <= 1'b0;
      if (cmd_accept) begin
        cmd_q <= reg_wdata;
        if (!init_zero) begin
          pending_q      <= 1'b1;
          card_req       <= 1'b1;
          card_req_index <= new_f.index;
          card_req_arg   <= {argh_q, argl_q};
          if (new_f.ctype == CT_DATA) begin
            xfer_active <= 1'b1;
            xfer_dir    <= new_f.dir;
            fifo_flush  <= 1'b1;
          end else begin
            xfer_active <= 1'b0;
          end
        end
      end
      if (disable_wr) begin
        pending_q  <= 1'b0;
        fifo_flush <= 1'b1;
      end
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd_addr[3]) begin
      reg_rdata <= rsp_rd;
    end else begin
      unique case (reg_rd_addr)
        A_CMD:   reg_rdata <= cmd_q;
        A_ARGL:  reg_rdata <= argl_q;
        A_ARGH:  reg_rdata <= argh_q;
        A_CTRL:  reg_rdata <= ctrl_q;
        A_STAT:  reg_rdata <= status_q;
        A_IE:    reg_rdata <= REG_W'(ie_q);
        default: reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/cmdst_checker.sv
module cmdst_checker #(
  parameter int IE_W = 15
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic [3:0]      reg_addr,
  input logic [15:0]     reg_wdata,
  input logic            card_rsp_valid,
  input logic            card_req,
  input logic            xfer_active,
  input logic            irq,
  input logic            pending_q,
  input logic            enable_q,
  input logic [15:0]     status_q,
  input logic [IE_W-1:0] ie_q
);

  p_irq_masked_r12: assert property (@(posedge clk) disable iff (rst)
    irq == |(status_q[IE_W-1:0] & ie_q));

  p_req_single_r3: assert property (@(posedge clk) disable iff (rst)
    card_req |=> !card_req);

  p_gate_off_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'd0 && (!enable_q || pending_q)) |=> !card_req);

  p_disable_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'd3 && !reg_wdata[11]) |=> (status_q == 16'd0));

  p_data_arm_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'd0 && enable_q && !pending_q &&
     reg_wdata[13:12] == 2'd3 && !(reg_wdata[7] && reg_wdata[5:0] == 6'd0))
    |=> xfer_active);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (pending_q && card_rsp_valid && !(reg_wr && reg_addr == 4'd3))
    |=> (status_q[0] || status_q[7]));

endmodule

bind cmd_status_unit cmdst_checker #(.IE_W(IE_W)) u_cmdst_checker (
  .clk           (clk),
  .rst           (rst),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .card_rsp_valid(card_rsp_valid),
  .card_req      (card_req),
  .xfer_active   (xfer_active),
  .irq           (irq),
  .pending_q     (pending_q),
  .enable_q      (enable_q),
  .status_q      (status_q),
  .ie_q          (ie_q)
);

// File: tb/cmd_status_unit_tb.sv
module cmd_status_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         reg_wr;
  logic [3:0]   reg_addr;
  logic [15:0]  reg_wdata;
  logic [3:0]   reg_rd_addr;
  logic [15:0]  reg_rdata;
  logic         card_req;
  logic [5:0]   card_req_index;
  logic [31:0]  card_req_arg;
  logic         card_rsp_valid;
  logic [4:0]   card_rsp_len;
  logic [127:0] card_rsp_data;
  logic         xfer_active, xfer_dir, fifo_flush, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_status_unit dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .card_req(card_req), .card_req_index(card_req_index),
    .card_req_arg(card_req_arg), .card_rsp_valid(card_rsp_valid),
    .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data),
    .xfer_active(xfer_active), .xfer_dir(xfer_dir),
    .fifo_flush(fifo_flush), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    reg_rd_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic reply(logic [4:0] len, logic [127:0] data);
    card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_data = data;
    @(negedge clk);
    card_rsp_valid = 1'b0;
  endtask

  function automatic logic [127:0] ramp(logic [7:0] base);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = base + 8'(i);
    return v;
  endfunction

  function automatic logic [127:0] status_bytes(logic [31:0] w);
    return {96'h0, w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic clear_status();
    wr(4'd4, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(4'd4, d); check("R11 reset status", d, 16'h0);
    check("R12 reset irq", irq, 0);
    rd(4'd15, d); check("R9 reset rsp", d, 16'h0);
  endtask

  task automatic t_disabled_ignore();
    logic [15:0] d;
    wr(4'd0, 16'h0111);
    check("R1 no request while disabled", card_req, 0);
    rd(4'd0, d); check("R1 cmd reg unchanged", d, 16'h0);
  endtask

  task automatic t_issue_r1();
    logic [15:0] d;
    wr(4'd3, 16'h0800);
    wr(4'd1, 16'h5678);
    wr(4'd2, 16'h1234);
    wr(4'd0, 16'h0111);
    check("R3 request pulse", card_req, 1);
    check("R3 request index", card_req_index, 6'd17);
    check("R3 request arg", card_req_arg, 32'h1234_5678);
    @(negedge clk);
    check("R3 pulse one cycle", card_req, 0);
    wr(4'd0, 16'h0112);
    check("R1 no request while pending", card_req, 0);
    reply(5'd4, status_bytes(32'h0200_0900));
    rd(4'd4, d); check("R8 done only, unmasked bit ignored R6", d, 16'h0001);
    rd(4'd7 + 4'd8, d); check("R9 rsp7 bytes0/1", d, 16'h0200);
    rd(4'd6 + 4'd8, d); check("R9 rsp6 bytes2/3", d, 16'h0900);
    rd(4'd0, d); check("R1 cmd reg holds accepted cmd", d, 16'h0111);
    clear_status();
    wr(4'd0, 16'h0111);
    reply(5'd4, status_bytes(32'h8000_0000));
    rd(4'd4, d); check("R6 card error bit14", d, 16'h4001);
    clear_status();
    wr(4'd0, 16'h0911);
    reply(5'd4, status_bytes(32'h0008_0000));
    rd(4'd4, d); check("R6 busy class error bit19", d, 16'h4001);
    clear_status();
  endtask

  task automatic t_short_and_r2();
    logic [15:0] d;
    wr(4'd0, 16'h0111);
    reply(5'd3, ramp(8'h10));
    rd(4'd4, d); check("R5 short class1 timeout", d, 16'h0080);
    rd(4'd15, d); check("R5 rsp stays zero", d, 16'h0);
    clear_status();
    wr(4'd0, 16'h0202);
    reply(5'd16, ramp(8'h20));
    rd(4'd4, d); check("R8 class2 done", d, 16'h0001);
    for (int j = 0; j < 8; j++) begin
      int k = 7 - j;
      rd(4'(8 + j), d);
      check("R9 class2 mapping", d, {8'h20 + 8'(2*k), 8'h20 + 8'(2*k+1)});
    end
    clear_status();
    wr(4'd0, 16'h0203);
    rd(4'd15, d); check("R9 cleared on command write", d, 16'h0);
    reply(5'd15, ramp(8'h40));
    rd(4'd4, d); check("R5 class2 15 bytes timeout", d, 16'h0080);
    clear_status();
  endtask

  task automatic t_r3_stop_none();
    logic [15:0] d;
    wr(4'd0, 16'h0329);
    reply(5'd4, status_bytes(32'h00FF_8000));
    rd(4'd4, d); check("R7 bit31 clear sets bit12", d, 16'h1001);
    clear_status();
    wr(4'd0, 16'h0329);
    reply(5'd4, status_bytes(32'h80FF_8000));
    rd(4'd4, d); check("R7 bit31 set no bit12", d, 16'h0001);
    clear_status();
    wr(4'd0, 16'h010C);
    reply(5'd4, status_bytes(32'h0));
    rd(4'd4, d); check("R8 index12 bits0,2", d, 16'h0005);
    clear_status();
    wr(4'd0, 16'h0505);
    reply(5'd0, ramp(8'h60));
    rd(4'd4, d); check("R13 class5 done no timeout", d, 16'h0001);
    rd(4'd15, d); check("R13 class5 nothing stored", d, 16'h0);
    reply(5'd16, ramp(8'h70));
    rd(4'd15, d); check("R13 unsolicited reply ignored", d, 16'h0);
    clear_status();
  endtask

  task automatic t_init_zero();
    logic [15:0] d;
    wr(4'd0, 16'h0180);
    check("R4 no request", card_req, 0);
    rd(4'd4, d); check("R4 status bit0", d, 16'h0001);
    wr(4'd0, 16'h0101);
    check("R4 nothing pending after init", card_req, 1);
    reply(5'd4, 128'h0);
    clear_status();
  endtask

  task automatic t_xfer();
    wr(4'd0, 16'hB111);
    check("R10 flush pulse", fifo_flush, 1);
    check("R10 xfer active", xfer_active, 1);
    check("R10 direction", xfer_dir, 1);
    reply(5'd4, 128'h0);
    wr(4'd0, 16'h2111);
    check("R10 other type cancels", xfer_active, 0);
    reply(5'd4, 128'h0);
    clear_status();
  endtask

  task automatic t_irq_w1c();
    logic [15:0] d;
    wr(4'd5, 16'hFF7F);
    wr(4'd0, 16'h0111);
    reply(5'd2, 128'h0);
    check("R12 timeout masked off", irq, 0);
    rd(4'd5, d); check("R12 mask 15 bits", d, 16'h7F7F);
    wr(4'd5, 16'h0080);
    @(negedge clk);
    check("R12 irq raised", irq, 1);
    wr(4'd4, 16'h0001);
    rd(4'd4, d); check("R11 w1c other bit kept", d, 16'h0080);
    wr(4'd4, 16'h0080);
    @(negedge clk);
    check("R12 irq drops", irq, 0);
    wr(4'd5, 16'h0000);
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    wr(4'd0, 16'h0111);
    reply(5'd4, 128'h0);
    wr(4'd0, 16'h0111);
    reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 16'h0001;
    card_rsp_valid = 1'b1; card_rsp_len = 5'd4; card_rsp_data = 128'h0;
    @(negedge clk);
    reg_wr = 1'b0; card_rsp_valid = 1'b0;
    rd(4'd4, d); check("R11 set wins over clear", d, 16'h0001);
    wr(4'd4, 16'h0001);
    rd(4'd4, d); check("R11 lone clear", d, 16'h0000);
  endtask

  task automatic t_disable();
    logic [15:0] d;
    wr(4'd0, 16'h0111);
    reply(5'd2, 128'h0);
    wr(4'd0, 16'h0111);
    wr(4'd3, 16'h0000);
    check("R2 flush pulse", fifo_flush, 1);
    rd(4'd4, d); check("R2 status zeroed", d, 16'h0);
    wr(4'd3, 16'h0800);
    wr(4'd0, 16'h0111);
    check("R2 wait dropped", card_req, 1);
    reply(5'd4, 128'h0);
  endtask

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; reg_rd_addr = '0;
    card_rsp_valid = 1'b0; card_rsp_len = '0; card_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled_ignore();
    t_issue_r1();
    t_short_and_r2();
    t_r3_stop_none();
    t_init_zero();
    t_xfer();
    t_irq_w1c();
    t_same_cycle();
    t_disable();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule